// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Source Bank

This block holds a set of interrupt sources and forwards them, one at a time, to a single presentation port that leads to a per-processor interrupt presenter. Each source is fixed at build time as edge-type (message-signalled) or level-type. A parameter mask picks the type of each source. Each source has a destination server number and an 8-bit priority, both written through a configuration port. A priority of 0xFF masks the source.

For every source the bank keeps a sampled line value (the asserted flag), a sent flag, a rejected flag, a masked-pending flag and a queued request. The presenter reports back through reject and end-of-interrupt notifications. It also issues a resend command when it can take more work. Commands name a source by its global interrupt number, which is the source index plus the parameter `BASE`. Queued requests leave on a valid/ready port. The lowest source index goes first.

Top module: `irq_source_bank`

## Requirements
- R1: After reset every priority is 0xFF, every flag and request is clear and `pres_valid` is low. With this default a rising line on any source presents nothing.
- R2: A configuration write, reject or end-of-interrupt whose number lies outside `BASE` to `BASE+NSRC-1` changes no state.
- R3: An edge source (a `LEVEL_MASK` bit of 0) that sees a rising line while unmasked is queued for presentation. If it is masked, it sets masked-pending instead. A later configuration write with a priority other than 0xFF clears masked-pending and queues the source.
- R4: A level source (a `LEVEL_MASK` bit of 1) is evaluated when its line changes, when it receives a configuration write, or on a resend. When the source is unmasked, its line is high and its sent flag is clear, the evaluation queues the source and sets sent. While sent is set the source is not queued again.
- R5: A source whose priority is currently 0xFF is never shown on the port, even if it is queued. It stays queued until it is unmasked.
- R6: A reject sets the source's rejected flag. On a resend, an edge source with rejected set clears the flag and is queued if it is unmasked. Without a resend it stays quiet.
- R7: A reject clears the sent flag of a level source, so a resend queues it again if its line is still high.
- R8: An end-of-interrupt clears the sent flag of a level source. The source is queued again only at its next evaluation event. An end-of-interrupt to an edge source has no effect.
- R9: A configuration write stores the server and priority. For a level source it also triggers an evaluation that uses the new priority.
- R10: The port shows the lowest-index queued, unmasked source with `pres_num` = `BASE` + index. A request leaves only on a cycle with `pres_valid` and `pres_ready` both high, and at most one leaves per cycle.
- R11: `pres_server` and `pres_prio` carry the current server and priority of the source shown.
- R12: Within one cycle the updates apply in this order: the grant removes the granted request, then the reject, the end-of-interrupt, the line edge (an edge source tests the old priority), the configuration write and finally the resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_line | input | NSRC | Interrupt line of each source |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_num | input | NUM_W | Global number to configure |
| cfg_server | input | SRV_W | New destination server |
| cfg_prio | input | 8 | New priority, 0xFF masks |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | NUM_W | Global number rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number completed |
| resend | input | 1 | Re-evaluate every source |
| pres_valid | output | 1 | A source is offered |
| pres_ready | input | 1 | Presenter accepts the offer |
| pres_num | output | NUM_W | Global number offered |
| pres_server | output | SRV_W | Server of the offered source |
| pres_prio | output | 8 | Priority of the offered source |

## Verification
Directed phases come first. Lone edges on masked and unmasked edge sources show the difference between masked-pending and immediate queuing. Held-high level lines, combined with end-of-interrupt, reject and resend, show whether the sent flag gates re-presentation. Out-of-range numbers are sent to check that decoding is bounded. Several lines rise together while ready is held low to expose the arbitration order and the hold behaviour. Last comes a long seeded random mix in which line toggles, writes that mask and unmask, rejects, completions and resends often land in the same cycle. That mix tests the within-cycle update order against a reference model.

// File: rtl/irq_source_bank.sv
module irq_source_bank #(
  parameter int NSRC = 8,
  parameter int SRV_W = 4,
  parameter int NUM_W = 8,
  parameter int BASE = 16,
  parameter logic [NSRC-1:0] LEVEL_MASK = NSRC'(8'hF0)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_line,
  input  logic             cfg_valid,
  input  logic [NUM_W-1:0] cfg_num,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend,
  output logic             pres_valid,
  input  logic             pres_ready,
  output logic [NUM_W-1:0] pres_num,
  output logic [SRV_W-1:0] pres_server,
  output logic [7:0]       pres_prio
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [NUM_W:0] LO = (NUM_W+1)'(BASE);
  localparam logic [NUM_W:0] HI = (NUM_W+1)'(BASE + NSRC);
  localparam logic [7:0] MASKED = 8'hFF;

  logic [NSRC-1:0] line_q, sent, rejd, mpend, req;
  logic [NSRC-1:0][7:0] prio;
  logic [NSRC-1:0][SRV_W-1:0] srv;

  logic [NSRC-1:0] cfg_hit, rej_hit, eoi_hit, elig, gnt;
  logic [NSRC-1:0] sent_n, rejd_n, mpend_n, req_n;
  logic [NSRC-1:0][7:0] prio_n;
  logic [IDX_W-1:0] sel;

  function automatic logic [NSRC-1:0] decode(input logic v, input logic [NUM_W-1:0] n);
    logic [NUM_W:0] d;
    logic [NSRC-1:0] r;
    d = {1'b0, n} - LO;
    r = '0;
    if (v && ({1'b0, n} >= LO) && ({1'b0, n} < HI))
      for (int k = 0; k < NSRC; k++)
        if (d[IDX_W-1:0] == IDX_W'(k)) r[k] = 1'b1;
    return r;
  endfunction

  assign cfg_hit = decode(cfg_valid, cfg_num);
  assign rej_hit = decode(rej_valid, rej_num);
  assign eoi_hit = decode(eoi_valid, eoi_num);

  always_comb begin
    sel = '0;
    for (int k = NSRC-1; k >= 0; k--)
      if (elig[k]) sel = IDX_W'(k);
  end

  assign pres_valid  = |elig;
  assign pres_num    = LO[NUM_W-1:0] + NUM_W'(sel);
  assign pres_server = srv[sel];
  assign pres_prio   = prio[sel];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign elig[i]   = req[i] && (prio[i] != MASKED);
    assign gnt[i]    = pres_valid && pres_ready && (sel == IDX_W'(i));
    assign prio_n[i] = cfg_hit[i] ? cfg_prio : prio[i];

    always_comb begin
      req_n[i]   = req[i] & ~gnt[i];
      sent_n[i]  = sent[i];
      rejd_n[i]  = rejd[i];
      mpend_n[i] = mpend[i];
      if (rej_hit[i]) begin
        rejd_n[i] = 1'b1;
        sent_n[i] = 1'b0;
      end
      if (LEVEL_MASK[i]) begin
        if (eoi_hit[i]) sent_n[i] = 1'b0;
        if (((src_line[i] ^ line_q[i]) || cfg_hit[i] || resend) &&
            (prio_n[i] != MASKED) && src_line[i] && !sent_n[i]) begin
          sent_n[i] = 1'b1;
          req_n[i]  = 1'b1;
        end
      end else begin
        if (src_line[i] && !line_q[i]) begin
          if (prio[i] == MASKED) mpend_n[i] = 1'b1;
          else req_n[i] = 1'b1;
        end
        if (cfg_hit[i] && mpend_n[i] && (cfg_prio != MASKED)) begin
          mpend_n[i] = 1'b0;
          req_n[i]   = 1'b1;
        end
        if (resend && rejd_n[i]) begin
          rejd_n[i] = 1'b0;
          if (prio_n[i] != MASKED) req_n[i] = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_q[i] <= 1'b0;
        sent[i]   <= 1'b0;
        rejd[i]   <= 1'b0;
        mpend[i]  <= 1'b0;
        req[i]    <= 1'b0;
        prio[i]   <= MASKED;
        srv[i]    <= '0;
      end else begin
        line_q[i] <= src_line[i];
        sent[i]   <= sent_n[i];
        rejd[i]   <= rejd_n[i];
        mpend[i]  <= mpend_n[i];
        req[i]    <= req_n[i];
        prio[i]   <= prio_n[i];
        if (cfg_hit[i]) srv[i] <= cfg_server;
      end
    end

    if (LEVEL_MASK[i]) begin : g_lvl_chk
      // R4
      sent_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sent[i]) |-> req[i]);
      // R7
      rej_clears_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_hit[i] && !resend && !cfg_hit[i] && (src_line[i] == line_q[i])) |=> !sent[i]);
    end else begin : g_edge_chk
      // R3
      mpend_only_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mpend[i]) |-> $past(prio[i]) == MASKED);
    end
  end

  // R5
  never_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> pres_prio != MASKED);
  // R2
  cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && (cfg_hit == '0)) |=> $stable(prio));
  // R10
  hold_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_valid && !pres_ready && (rej_hit == '0) && !cfg_valid) |=> pres_valid);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!pres_valid && (req == '0)));
endmodule

// File: tb/irq_source_bank_tb.sv
`timescale 1ns/1ps
module irq_source_bank_tb;
  localparam int NSRC = 8, SRV_W = 4, NUM_W = 8, BASE = 16;
  localparam logic [NSRC-1:0] LVL = 8'hF0;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [NSRC-1:0] src_line;
  logic cfg_valid, rej_valid, eoi_valid, resend, pres_ready;
  logic [NUM_W-1:0] cfg_num, rej_num, eoi_num;
  logic [SRV_W-1:0] cfg_server;
  logic [7:0] cfg_prio;
  logic pres_valid;
  logic [NUM_W-1:0] pres_num;
  logic [SRV_W-1:0] pres_server;
  logic [7:0] pres_prio;

  irq_source_bank #(.NSRC(NSRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE(BASE), .LEVEL_MASK(LVL)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_line(src_line),
    .cfg_valid(cfg_valid), .cfg_num(cfg_num), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend(resend), .pres_valid(pres_valid), .pres_ready(pres_ready),
    .pres_num(pres_num), .pres_server(pres_server), .pres_prio(pres_prio));

  bit m_req[NSRC], m_sent[NSRC], m_rej[NSRC], m_mp[NSRC], m_lq[NSRC];
  logic [7:0] m_prio[NSRC];
  logic [SRV_W-1:0] m_srv[NSRC];
  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  function automatic bit hit(input logic v, input logic [NUM_W-1:0] n, input int i);
    return v && (int'(n) == BASE + i);
  endfunction

  function automatic int exp_sel();
    for (int i = 0; i < NSRC; i++)
      if (m_req[i] && m_prio[i] != 8'hFF) return i;
    return -1;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NSRC; i++) begin
      m_req[i] = 0; m_sent[i] = 0; m_rej[i] = 0; m_mp[i] = 0; m_lq[i] = 0;
      m_prio[i] = 8'hFF; m_srv[i] = '0;
    end
  endtask

  task automatic tick();
    int s;
    #1;
    s = exp_sel();
    chk("pres_valid", 32'(pres_valid), 32'(s >= 0));
    if (s >= 0) begin
      chk("pres_num", 32'(pres_num), 32'(BASE + s));
      chk("pres_server", 32'(pres_server), 32'(m_srv[s]));
      chk("pres_prio", 32'(pres_prio), 32'(m_prio[s]));
    end
    for (int i = 0; i < NSRC; i++) begin
      bit q, sn, r, mp, ch;
      logic [7:0] np;
      ch = hit(cfg_valid, cfg_num, i);
      np = ch ? cfg_prio : m_prio[i];
      q = m_req[i] && !(s == i && pres_ready);
      sn = m_sent[i]; r = m_rej[i]; mp = m_mp[i];
      if (hit(rej_valid, rej_num, i)) begin r = 1; sn = 0; end
      if (LVL[i]) begin
        if (hit(eoi_valid, eoi_num, i)) sn = 0;
        if (((src_line[i] != m_lq[i]) || ch || resend) && np != 8'hFF && src_line[i] && !sn) begin
          sn = 1; q = 1;
        end
      end else begin
        if (src_line[i] && !m_lq[i]) begin
          if (m_prio[i] == 8'hFF) mp = 1; else q = 1;
        end
        if (ch && mp && cfg_prio != 8'hFF) begin mp = 0; q = 1; end
        if (resend && r) begin r = 0; if (np != 8'hFF) q = 1; end
      end
      m_req[i] = q; m_sent[i] = sn; m_rej[i] = r; m_mp[i] = mp;
      m_prio[i] = np; m_lq[i] = src_line[i];
      if (ch) m_srv[i] = cfg_server;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_valid = 0; rej_valid = 0; eoi_valid = 0; resend = 0;
  endtask

  task automatic do_cfg(input int n, input int sv, input int p);
    cfg_valid = 1; cfg_num = NUM_W'(n); cfg_server = SRV_W'(sv); cfg_prio = 8'(p);
    tick(); idle();
  endtask
  task automatic do_rej(input int n);
    rej_valid = 1; rej_num = NUM_W'(n); tick(); idle();
  endtask
  task automatic do_eoi(input int n);
    eoi_valid = 1; eoi_num = NUM_W'(n); tick(); idle();
  endtask
  task automatic do_resend();
    resend = 1; tick(); idle();
  endtask
  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 0; src_line = '0; pres_ready = 1; idle();
    cfg_num = '0; rej_num = '0; eoi_num = '0; cfg_server = '0; cfg_prio = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    chk("reset pres_valid", 32'(pres_valid), 32'd0);
    src_line[0] = 1; src_line[5] = 1; wait_n(3);
    src_line = '0; wait_n(2);

    tag = "R2";
    do_cfg(BASE - 1, 2, 3);
    do_cfg(BASE + NSRC, 2, 3);
    do_rej(BASE + NSRC + 1);
    src_line[7] = 1; wait_n(2); src_line[7] = 0; wait_n(1);

    tag = "R3";
    do_cfg(BASE + 0, 3, 5);
    src_line[0] = 1; wait_n(3);
    src_line[1] = 1; wait_n(2);
    do_cfg(BASE + 1, 6, 4); wait_n(2);

    tag = "R9";
    src_line[4] = 1; wait_n(2);
    do_cfg(BASE + 4, 9, 2);
    tag = "R4"; wait_n(3);

    tag = "R8";
    do_eoi(BASE + 4); wait_n(1);
    do_resend(); wait_n(1);
    do_eoi(BASE + 0); wait_n(1);

    tag = "R6";
    src_line[0] = 0; wait_n(1); src_line[0] = 1; wait_n(2);
    do_rej(BASE + 0); wait_n(2);
    do_resend(); wait_n(2);

    tag = "R7";
    do_rej(BASE + 4); wait_n(1);
    do_resend(); wait_n(2);

    tag = "R5";
    pres_ready = 0;
    src_line[0] = 0; wait_n(1); src_line[0] = 1; wait_n(1);
    do_cfg(BASE + 0, 3, 8'hFF); wait_n(1);
    do_cfg(BASE + 0, 3, 1);

    tag = "R10";
    do_cfg(BASE + 2, 1, 7); do_cfg(BASE + 3, 2, 9); do_cfg(BASE + 6, 5, 3);
    src_line[3:2] = 2'b11; src_line[6] = 1; wait_n(3);
    pres_ready = 1; wait_n(5);

    tag = "R11";
    do_cfg(BASE + 6, 12, 200);
    src_line[6] = 0; wait_n(1); src_line[6] = 1; wait_n(2);

    tag = "R12";
    for (int c = 0; c < 6000; c++) begin
      pres_ready = ($urandom % 4) != 0;
      for (int b = 0; b < NSRC; b++)
        if (($urandom % 8) == 0) src_line[b] = ~src_line[b];
      cfg_valid = ($urandom % 6) == 0;
      cfg_num = NUM_W'(BASE - 2 + int'($urandom % (NSRC + 4)));
      cfg_server = SRV_W'($urandom);
      cfg_prio = (($urandom % 3) == 0) ? 8'hFF : 8'($urandom % 255);
      rej_valid = ($urandom % 8) == 0;
      rej_num = NUM_W'(BASE - 2 + int'($urandom % (NSRC + 4)));
      eoi_valid = ($urandom % 8) == 0;
      eoi_num = NUM_W'(BASE - 2 + int'($urandom % (NSRC + 4)));
      resend = ($urandom % 10) == 0;
      tick();
    end
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule